// File: doc/BRIEF.md
# Instruction Sequencer with Per-Unit Clock Enables

This block is the control unit of a small 8-bit controller. It reads each 16-bit instruction from an instruction ROM as two bytes, decodes it and drives the datapath selects and strobes. The register file, ALU, shifter, data RAM and the two ports sit outside this block. Each of those units also gets its own clock-enable line from this block. A unit's enable is high only while the current instruction needs that unit. Gating works through these enables, and the clock net itself is never switched.

An external compare input makes it possible to silence one opcode at run time. When `gate_en` is high and the decoded opcode equals `gate_op`, that instruction raises no unit enable and no strobe. Program flow is unchanged. The block has no streaming interface. The ROM is read combinationally, and every other pin is a plain control or status line, so there is no back-pressure to handle.

Top module: `cgcu_top`

## Requirements
- R1: While `rst` is high the sequencer is held at the first reset step and all unit enables are low. After `rst` falls, two reset steps pass, and then the first fetch presents `START_PC` on `rom_addr`.
- R2: Each instruction takes five cycles: fetch-low, fetch-high, decode, execute, writeback. `rom_addr` equals the PC in the first fetch cycle and PC+1 in the second. Byte 0 holds the opcode in bits [7:2] and RAM address bits [9:8] in bits [1:0]. Byte 1 holds RAM address bits [7:0].
- R3: After each instruction the PC advances by 2. Opcode 0x03 (jump) instead loads byte 1 as the new PC.
- R4: `ram_addr` carries the 10-bit direct address from the instruction while it executes.
- R5: Unit enable bits are indexed as 0 register file, 1 ALU, 2 shifter, 3 RAM, 4 output port, 5 input port. The enable mask for each opcode is:
  - 0x01 load: RF and RAM
  - 0x02 store: RAM
  - 0x04 to 0x08 (add, sub, and, or, xor with a RAM operand): RF, ALU and RAM
  - 0x09 shift left and 0x0A shift right: RF and shifter
  - 0x0B write to port 0: port 0
  - 0x0C read from port 1: RF and port 1
  - 0x00 and 0x03: none
- R6: Unit enables are registered. They are high only in the execute and writeback cycles and are zero during fetch and decode.
- R7: `ram_we`, `p0_stb` and `p1_stb` pulse in the execute cycle. `rf_we` pulses in the writeback cycle. Each pulses only while its own unit is enabled.
- R8: `alu_op` uses 0 add, 1 sub, 2 and, 3 or, 4 xor. `sh_right` is 1 for a right shift. `rf_src` selects 0 RAM, 1 ALU, 2 shifter, 3 input port.
- R9: When `gate_en` is high and the opcode equals `gate_op`, that instruction raises no enable and no strobe. Its PC update, including a jump, still happens.
- R10: Opcodes 0x0D to 0x3F act as no-operation: no enable, no strobe, PC+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rom_addr | output | PC_W | Instruction ROM byte address |
| rom_data | input | 8 | Instruction ROM byte read combinationally |
| ram_addr | output | 10 | Direct data RAM address |
| ram_we | output | 1 | Data RAM write strobe |
| rf_we | output | 1 | Register file write strobe |
| rf_src | output | 2 | Register file write source select |
| alu_op | output | 3 | ALU operation select |
| sh_right | output | 1 | Shift direction, 1 is right |
| p0_stb | output | 1 | Output port write strobe |
| p1_stb | output | 1 | Input port read strobe |
| gate_en | input | 1 | Enable for the opcode compare |
| gate_op | input | 6 | Opcode whose units are held unclocked |
| unit_en | output | 6 | Per-unit clock enables |

## Verification
The bench builds the block with `PC_W` = 8 and `START_PC` = 0x10. A non-zero reset vector makes a missing load of the program counter visible, and it lets a backward jump land on the program's first instruction again. A behavioural accumulator, RAM and ALU follow the strobes. Port writes then expose the arithmetic results, and they show that a gated instruction left state untouched. The program runs a jump across a gap and gates an ALU op, a load and a jump. It also issues an undefined opcode, and at the end reset is asserted in the middle of an instruction.

// File: rtl/cgcu_pkg.sv
package cgcu_pkg;
  localparam int DW      = 8;
  localparam int OP_W    = 6;
  localparam int ADDR_W  = 2*DW - OP_W;
  localparam int N_UNITS = 6;

  localparam int U_RF  = 0;
  localparam int U_ALU = 1;
  localparam int U_SH  = 2;
  localparam int U_RAM = 3;
  localparam int U_P0  = 4;
  localparam int U_P1  = 5;

  localparam logic [OP_W-1:0] OPC_NOP = 6'h00;
  localparam logic [OP_W-1:0] OPC_LD  = 6'h01;
  localparam logic [OP_W-1:0] OPC_ST  = 6'h02;
  localparam logic [OP_W-1:0] OPC_JMP = 6'h03;
  localparam logic [OP_W-1:0] OPC_ADD = 6'h04;
  localparam logic [OP_W-1:0] OPC_SUB = 6'h05;
  localparam logic [OP_W-1:0] OPC_AND = 6'h06;
  localparam logic [OP_W-1:0] OPC_OR  = 6'h07;
  localparam logic [OP_W-1:0] OPC_XOR = 6'h08;
  localparam logic [OP_W-1:0] OPC_SHL = 6'h09;
  localparam logic [OP_W-1:0] OPC_SHR = 6'h0A;
  localparam logic [OP_W-1:0] OPC_OUT = 6'h0B;
  localparam logic [OP_W-1:0] OPC_IN  = 6'h0C;

  localparam logic [1:0] SRC_RAM = 2'd0;
  localparam logic [1:0] SRC_ALU = 2'd1;
  localparam logic [1:0] SRC_SH  = 2'd2;
  localparam logic [1:0] SRC_P1  = 2'd3;

  typedef enum logic [2:0] {
    ST_RST1, ST_RST2, ST_F1, ST_F2, ST_DEC, ST_EXE, ST_WB
  } state_t;

  typedef struct packed {
    logic [N_UNITS-1:0] mask;
    logic               is_jmp;
    logic               ram_wr;
    logic               p0_wr;
    logic               p1_rd;
    logic               rf_wr;
    logic [2:0]         alu_op;
    logic               sh_right;
    logic [1:0]         rf_src;
  } dec_t;
endpackage

// File: rtl/cgcu_decode.sv
module cgcu_decode
  import cgcu_pkg::*;
(
  input  logic [OP_W-1:0] opcode,
  output dec_t            dec
);
  always_comb begin
    dec = '0;
    unique case (opcode)
      OPC_LD: begin
        dec.mask[U_RF]  = 1'b1;
        dec.mask[U_RAM] = 1'b1;
        dec.rf_wr       = 1'b1;
        dec.rf_src      = SRC_RAM;
      end
      OPC_ST: begin
        dec.mask[U_RAM] = 1'b1;
        dec.ram_wr      = 1'b1;
      end
      OPC_JMP: dec.is_jmp = 1'b1;
      OPC_ADD, OPC_SUB, OPC_AND, OPC_OR, OPC_XOR: begin
        dec.mask[U_RF]  = 1'b1;
        dec.mask[U_ALU] = 1'b1;
        dec.mask[U_RAM] = 1'b1;
        dec.rf_wr       = 1'b1;
        dec.rf_src      = SRC_ALU;
        dec.alu_op      = 3'(opcode - OPC_ADD);
      end
      OPC_SHL, OPC_SHR: begin
        dec.mask[U_RF]  = 1'b1;
        dec.mask[U_SH]  = 1'b1;
        dec.rf_wr       = 1'b1;
        dec.rf_src      = SRC_SH;
        dec.sh_right    = (opcode == OPC_SHR);
      end
      OPC_OUT: begin
        dec.mask[U_P0]  = 1'b1;
        dec.p0_wr       = 1'b1;
      end
      OPC_IN: begin
        dec.mask[U_RF]  = 1'b1;
        dec.mask[U_P1]  = 1'b1;
        dec.p1_rd       = 1'b1;
        dec.rf_wr       = 1'b1;
        dec.rf_src      = SRC_P1;
      end
      default: dec = '0;
    endcase
  end
endmodule

// File: rtl/cgcu_seq.sv
module cgcu_seq
  import cgcu_pkg::*;
#(
  parameter int PC_W     = 8,
  parameter int START_PC = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              is_jmp,
  input  logic [DW-1:0]     rom_data,
  output state_t            state,
  output logic [PC_W-1:0]   rom_addr,
  output logic [OP_W-1:0]   opcode,
  output logic [ADDR_W-1:0] operand
);
  localparam int HI_W = DW - OP_W;

  logic [PC_W-1:0] pc;
  logic [OP_W-1:0] op_q;
  logic [HI_W-1:0] hi_q;
  logic [DW-1:0]   lo_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_RST1;
      pc    <= '0;
    end else begin
      unique case (state)
        ST_RST1: state <= ST_RST2;
        ST_RST2: begin
          pc    <= PC_W'(START_PC);
          state <= ST_F1;
        end
        ST_F1:  state <= ST_F2;
        ST_F2:  state <= ST_DEC;
        ST_DEC: state <= ST_EXE;
        ST_EXE: state <= ST_WB;
        ST_WB: begin
          pc    <= is_jmp ? PC_W'(lo_q) : pc + PC_W'(2);
          state <= ST_F1;
        end
        default: state <= ST_RST1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (state == ST_F1) {op_q, hi_q} <= rom_data;
    if (state == ST_F2) lo_q <= rom_data;
  end

  assign rom_addr = (state == ST_F2) ? pc + PC_W'(1) : pc;
  assign opcode   = op_q;
  assign operand  = {hi_q, lo_q};
endmodule

// File: rtl/cgcu_gate.sv
module cgcu_gate
  import cgcu_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  state_t             state,
  input  logic [N_UNITS-1:0] mask,
  input  logic [OP_W-1:0]    opcode,
  input  logic               gate_en,
  input  logic [OP_W-1:0]    gate_op,
  output logic [N_UNITS-1:0] unit_en,
  output logic               gated
);
  logic hit;
  assign hit = gate_en && (opcode == gate_op);

  always_ff @(posedge clk) begin
    if (rst)                  gated <= 1'b0;
    else if (state == ST_DEC) gated <= hit;
    else if (state == ST_WB)  gated <= 1'b0;
  end

  for (genvar i = 0; i < N_UNITS; i++) begin : g_en
    always_ff @(posedge clk) begin
      if (rst)                  unit_en[i] <= 1'b0;
      else if (state == ST_DEC) unit_en[i] <= mask[i] & ~hit;
      else if (state == ST_WB)  unit_en[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/cgcu_top.sv
module cgcu_top
  import cgcu_pkg::*;
#(
  parameter int PC_W     = 8,
  parameter int START_PC = 0
) (
  input  logic                   clk,
  input  logic                   rst,
  output logic [PC_W-1:0]        rom_addr,
  input  logic [7:0]             rom_data,
  output logic [9:0]             ram_addr,
  output logic                   ram_we,
  output logic                   rf_we,
  output logic [1:0]             rf_src,
  output logic [2:0]             alu_op,
  output logic                   sh_right,
  output logic                   p0_stb,
  output logic                   p1_stb,
  input  logic                   gate_en,
  input  logic [5:0]             gate_op,
  output logic [5:0]             unit_en
);
  state_t            state;
  logic [OP_W-1:0]   opcode;
  logic [ADDR_W-1:0] operand;
  dec_t              dec;
  logic              jmp_w;
  logic              gated;

  assign jmp_w = dec.is_jmp;

  cgcu_seq #(.PC_W(PC_W), .START_PC(START_PC)) u_seq (
    .clk(clk), .rst(rst), .is_jmp(jmp_w), .rom_data(rom_data),
    .state(state), .rom_addr(rom_addr), .opcode(opcode), .operand(operand)
  );

  cgcu_decode u_dec (.opcode(opcode), .dec(dec));

  cgcu_gate u_gate (
    .clk(clk), .rst(rst), .state(state), .mask(dec.mask), .opcode(opcode),
    .gate_en(gate_en), .gate_op(gate_op), .unit_en(unit_en), .gated(gated)
  );

  assign ram_addr = operand;
  assign rf_src   = dec.rf_src;
  assign alu_op   = dec.alu_op;
  assign sh_right = dec.sh_right;
  assign ram_we   = (state == ST_EXE) && dec.ram_wr && !gated;
  assign p0_stb   = (state == ST_EXE) && dec.p0_wr  && !gated;
  assign p1_stb   = (state == ST_EXE) && dec.p1_rd  && !gated;
  assign rf_we    = (state == ST_WB)  && dec.rf_wr  && !gated;
endmodule

// File: rtl/cgcu_checker.sv
module cgcu_checker
  import cgcu_pkg::*;
#(
  parameter int PC_W     = 8,
  parameter int START_PC = 0
) (
  input logic               clk,
  input logic               rst,
  input state_t             state,
  input logic [PC_W-1:0]    rom_addr,
  input logic [N_UNITS-1:0] unit_en,
  input logic               gated,
  input logic               is_jmp,
  input logic               ram_we,
  input logic               rf_we,
  input logic               p0_stb,
  input logic               p1_stb
);
  AST_RESET_VECTOR: assert property (@(posedge clk) disable iff (rst)
    (state == ST_F1 && $past(state) == ST_RST2) |-> rom_addr == PC_W'(START_PC)); // R1
  AST_FETCH_SECOND: assert property (@(posedge clk) disable iff (rst)
    (state == ST_F2) |-> rom_addr == $past(rom_addr) + PC_W'(1)); // R2
  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
    (state == ST_F1 && $past(state) == ST_WB && !$past(is_jmp))
      |-> rom_addr == $past(rom_addr) + PC_W'(2)); // R3
  AST_EN_IDLE: assert property (@(posedge clk) disable iff (rst)
    (state != ST_EXE && state != ST_WB) |-> unit_en == '0); // R6
  AST_EN_HELD: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WB) |-> unit_en == $past(unit_en)); // R6
  AST_RAMWE_EN: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> unit_en[U_RAM]); // R7
  AST_RFWE_EN: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> unit_en[U_RF]); // R7
  AST_PORT_EN: assert property (@(posedge clk) disable iff (rst)
    (p0_stb |-> unit_en[U_P0]) and (p1_stb |-> unit_en[U_P1])); // R7
  AST_GATED_QUIET: assert property (@(posedge clk) disable iff (rst)
    gated |-> (unit_en == '0 && !ram_we && !rf_we && !p0_stb && !p1_stb)); // R9
endmodule

bind cgcu_top cgcu_checker #(.PC_W(PC_W), .START_PC(START_PC)) u_chk (
  .clk(clk), .rst(rst), .state(state), .rom_addr(rom_addr), .unit_en(unit_en),
  .gated(gated), .is_jmp(jmp_w), .ram_we(ram_we), .rf_we(rf_we),
  .p0_stb(p0_stb), .p1_stb(p1_stb)
);

// File: tb/tb_cgcu_top.sv
module tb_cgcu_top;
  localparam int PC_W  = 8;
  localparam int START = 8'h10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [PC_W-1:0] rom_addr;
  logic [7:0] rom_data;
  logic [9:0] ram_addr;
  logic ram_we, rf_we, sh_right, p0_stb, p1_stb;
  logic [1:0] rf_src;
  logic [2:0] alu_op;
  logic gate_en = 1'b0;
  logic [5:0] gate_op = 6'h00;
  logic [5:0] unit_en;

  cgcu_top #(.PC_W(PC_W), .START_PC(START)) dut (
    .clk(clk), .rst(rst), .rom_addr(rom_addr), .rom_data(rom_data),
    .ram_addr(ram_addr), .ram_we(ram_we), .rf_we(rf_we), .rf_src(rf_src),
    .alu_op(alu_op), .sh_right(sh_right), .p0_stb(p0_stb), .p1_stb(p1_stb),
    .gate_en(gate_en), .gate_op(gate_op), .unit_en(unit_en)
  );

  // behavioural ROM, RAM, accumulator, ALU and shifter
  logic [7:0] rom [256];
  logic [7:0] ram [1024];
  logic [7:0] acc = 8'h00;
  logic [7:0] port1_val = 8'h5A;
  assign rom_data = rom[rom_addr];

  function automatic logic [7:0] alu_f(input logic [2:0] op, input logic [7:0] a, input logic [7:0] b);
    case (op)
      3'd0: return a + b;
      3'd1: return a - b;
      3'd2: return a & b;
      3'd3: return a | b;
      default: return a ^ b;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (unit_en[0] && rf_we)
      case (rf_src)
        2'd0: acc <= ram[ram_addr];
        2'd1: acc <= alu_f(alu_op, acc, ram[ram_addr]);
        2'd2: acc <= sh_right ? acc >> 1 : acc << 1;
        default: acc <= port1_val;
      endcase
    if (unit_en[3] && ram_we) ram[ram_addr] <= acc;
  end

  int checks = 0, errors = 0;
  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  typedef struct {
    logic [7:0] pc;
    logic [5:0] mask;
    bit         is_out;
    logic [7:0] p0;
    bit         has_addr;
    logic [9:0] addr;
    bit         g_en;
    logic [5:0] g_op;
    string      tag;
  } item_t;

  item_t q[$];
  int exp_cnt[6];
  int obs_cnt[6];
  bit ready = 0, mon_done = 0, done = 0;

  // driver: writes the instruction into ROM and pushes the expected item
  task automatic put(input logic [7:0] pc, input logic [5:0] op, input logic [9:0] a,
                     input logic [5:0] mask, input bit is_out, input logic [7:0] p0,
                     input bit g_en, input logic [5:0] g_op, input string tag);
    item_t it;
    rom[pc]     = {op, a[9:8]};
    rom[pc + 1] = a[7:0];
    it.pc = pc; it.mask = mask; it.is_out = is_out; it.p0 = p0;
    it.has_addr = (op != 6'h03) && (mask[3] || (g_en && op == g_op));
    it.addr = a; it.g_en = g_en; it.g_op = g_op; it.tag = tag;
    for (int u = 0; u < 6; u++) if (mask[u]) exp_cnt[u] += 2;
    q.push_back(it);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) rom[i] = 8'h00;
    for (int i = 0; i < 1024; i++) ram[i] = 8'h00;
    ram[10'h005] = 8'h3C; ram[10'h2A7] = 8'h0F; ram[10'h010] = 8'h81;
    put(8'h10, 6'h01, 10'h005, 6'h09, 0, 0, 0, 0, "R5 load");
    put(8'h12, 6'h04, 10'h2A7, 6'h0B, 0, 0, 0, 0, "R5 add");
    put(8'h14, 6'h0B, 10'h000, 6'h10, 1, 8'h4B, 0, 0, "R8 out add");
    put(8'h16, 6'h09, 10'h000, 6'h05, 0, 0, 0, 0, "R5 shl");
    put(8'h18, 6'h02, 10'h3FF, 6'h08, 0, 0, 0, 0, "R5 store");
    put(8'h1A, 6'h08, 10'h010, 6'h00, 0, 0, 1, 6'h08, "R9 gated xor");
    put(8'h1C, 6'h0B, 10'h000, 6'h10, 1, 8'h96, 1, 6'h08, "R9 out after gate");
    put(8'h1E, 6'h03, 10'h030, 6'h00, 0, 0, 1, 6'h08, "R3 jump");
    rom[8'h20] = 8'h2C; rom[8'h21] = 8'h00; // skipped by the jump
    put(8'h30, 6'h0A, 10'h000, 6'h05, 0, 0, 0, 0, "R3 shr at target");
    put(8'h32, 6'h06, 10'h010, 6'h0B, 0, 0, 0, 0, "R5 and");
    put(8'h34, 6'h05, 10'h005, 6'h0B, 0, 0, 0, 0, "R5 sub");
    put(8'h36, 6'h0C, 10'h000, 6'h21, 0, 0, 0, 0, "R5 in");
    put(8'h38, 6'h07, 10'h2A7, 6'h0B, 0, 0, 0, 0, "R4 or");
    put(8'h3A, 6'h08, 10'h010, 6'h0B, 0, 0, 0, 0, "R9 xor ungated");
    put(8'h3C, 6'h0B, 10'h000, 6'h10, 1, 8'hDE, 0, 0, "R8 out alu chain");
    put(8'h3E, 6'h01, 10'h3FF, 6'h09, 0, 0, 0, 0, "R4 load high addr");
    put(8'h40, 6'h0B, 10'h000, 6'h10, 1, 8'h96, 0, 0, "R7 out stored");
    put(8'h42, 6'h3F, 10'h000, 6'h00, 0, 0, 0, 0, "R10 undefined");
    put(8'h44, 6'h01, 10'h005, 6'h00, 0, 0, 1, 6'h01, "R9 gated load");
    put(8'h46, 6'h0B, 10'h000, 6'h10, 1, 8'h96, 1, 6'h01, "R9 out after gated load");
    put(8'h48, 6'h03, 10'h010, 6'h00, 0, 0, 1, 6'h03, "R9 gated jump");
    put(8'h10, 6'h01, 10'h005, 6'h09, 0, 0, 0, 0, "R3 back at start");
    ready = 1;

    repeat (3) @(negedge clk);
    chk(unit_en == 6'h00, "R1", "enables in reset", unit_en, 0);
    chk(!ram_we && !rf_we && !p0_stb && !p1_stb, "R1", "strobes in reset",
        {ram_we, rf_we, p0_stb, p1_stb}, 0);
    rst = 1'b0;

    wait (mon_done);
    repeat (4) @(negedge clk);
    chk(unit_en == 6'h0B, "R5", "add enables before reset", unit_en, 8'h0B);
    rst = 1'b1;
    @(negedge clk);
    chk(unit_en == 6'h00, "R1", "enables cleared by mid-run reset", unit_en, 0);
    chk(!rf_we && !ram_we, "R1", "strobes cleared by reset", {rf_we, ram_we}, 0);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk(rom_addr == START, "R1", "restart vector", rom_addr, START);
    chk(unit_en == 6'h00, "R6", "enables at restart fetch", unit_en, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  // monitor: pops one expected item per instruction and compares
  initial begin
    item_t it;
    wait (ready && !rst);
    @(posedge clk); @(posedge clk); @(negedge clk);
    while (q.size() > 0) begin
      it = q.pop_front();
      gate_en = it.g_en;
      gate_op = it.g_op;
      chk(rom_addr == it.pc, "R3", {it.tag, " pc"}, rom_addr, it.pc);
      chk(unit_en == 0, "R6", {it.tag, " fetch1 enables"}, unit_en, 0);
      @(negedge clk);
      chk(rom_addr == it.pc + 8'd1, "R2", {it.tag, " fetch2 addr"}, rom_addr, it.pc + 8'd1);
      chk(unit_en == 0, "R6", {it.tag, " fetch2 enables"}, unit_en, 0);
      @(negedge clk);
      chk(unit_en == 0, "R6", {it.tag, " decode enables"}, unit_en, 0);
      @(negedge clk);
      for (int u = 0; u < 6; u++) obs_cnt[u] += unit_en[u];
      chk(unit_en == it.mask, "R5", {it.tag, " execute mask"}, unit_en, it.mask);
      if (it.has_addr)
        chk(ram_addr == it.addr, "R4", {it.tag, " ram addr"}, ram_addr, it.addr);
      chk(ram_we == (it.mask == 6'h08), "R7", {it.tag, " ram_we"}, ram_we, it.mask == 6'h08);
      chk(p0_stb == it.mask[4], "R7", {it.tag, " p0_stb"}, p0_stb, it.mask[4]);
      chk(p1_stb == it.mask[5], "R7", {it.tag, " p1_stb"}, p1_stb, it.mask[5]);
      if (it.is_out) chk(acc == it.p0, "R8", {it.tag, " port value"}, acc, it.p0);
      @(negedge clk);
      for (int u = 0; u < 6; u++) obs_cnt[u] += unit_en[u];
      chk(unit_en == it.mask, "R6", {it.tag, " writeback mask"}, unit_en, it.mask);
      chk(rf_we == it.mask[0], "R7", {it.tag, " rf_we"}, rf_we, it.mask[0]);
      if (q.size() > 0) @(negedge clk);
    end
    gate_en = 1'b0;
    for (int u = 0; u < 6; u++)
      chk(obs_cnt[u] == exp_cnt[u], "R6", $sformatf("enabled cycles unit %0d", u), obs_cnt[u], exp_cnt[u]);
    mon_done = 1;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule